// File: doc/BRIEF.md
# Serial Flash Boot Image Reader

This block reads a configuration image out of an external serial flash after reset. It acts as the bus master. It drives an active-low chip select, the serial clock and the outgoing data line, and it samples the incoming data line. It sends one Fast Read transaction: the command byte 0x0B, then a 24-bit start address, then eight dummy clock periods. After that it collects the image one byte at a time.

Each assembled byte is offered on a valid/ready stream. The serial clock is held low while a byte waits to be accepted, so a slow consumer stalls the flash read without losing data. When the set number of bytes has been accepted, the block deselects the flash and pulses `done` for one cycle. It then holds `pins_released` high until the next reset. Pad logic outside the block uses `pins_released` to return the four serial pins to general-purpose use.

Top module: `flash_boot_reader`

## Requirements
- R1: While `rst_n` is low, `spi_cs_n` is 1, `spi_sck` is 0, and `out_valid`, `done` and `pins_released` are all 0.
- R2: `spi_cs_n` goes low before the first clock edge of the transaction and stays low until the last image byte is accepted. Whenever `spi_cs_n` is high, `spi_sck` is low.
- R3: The first eight bits on `spi_mosi`, taken at rising `spi_sck` edges, are the command 0x0B, sent most significant bit first.
- R4: The next 24 bits on `spi_mosi` are `START_ADDR`, sent most significant bit first.
- R5: Eight dummy clock periods follow the address, with `spi_mosi` held at 0. Image data starts at the 41st rising edge.
- R6: Each high phase of `spi_sck` lasts exactly `CLK_DIV` system clocks. `spi_mosi` changes only while `spi_sck` is low (SPI mode 0).
- R7: Each image byte is built from `spi_miso`, sampled on rising `spi_sck` edges with the most significant bit first, and is shown on `out_data` with `out_valid` high. While `out_ready` is low, `out_valid` and `out_data` hold steady.
- R8: While `out_valid` is high, `spi_sck` stays low and no clock edges are produced.
- R9: Exactly `BYTE_COUNT` bytes are delivered, using 40 + 8*`BYTE_COUNT` rising clock edges in total. `spi_cs_n` rises in the same cycle in which `done` is asserted.
- R10: `done` is high for exactly one cycle per image. `pins_released` rises together with `done` and stays high until reset. While it is high, `spi_cs_n` is 1, `spi_sck` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a new image read when released |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock to the flash, derived from `clk` |
| spi_mosi | output | 1 | Command and address bits to the flash |
| spi_miso | input | 1 | Image bits from the flash |
| out_data | output | 8 | Assembled image byte |
| out_valid | output | 1 | `out_data` holds a byte not yet accepted |
| out_ready | input | 1 | Consumer accepts the byte when high together with `out_valid` |
| done | output | 1 | One-cycle pulse when the last byte is accepted |
| pins_released | output | 1 | High from the end of the image until reset; the serial pins are free |

## Verification
The assertions check, on every cycle, the rules that relate pin levels to each other:
- the clock idles low when the flash is deselected;
- outgoing data stays steady during each high clock phase;
- a pending byte holds steady and stops the clock;
- `done` is a single pulse and `pins_released` is sticky, with the pins parked.

Some properties need a whole transaction to show. These are:
- the content of the 40 header bits;
- the exact length of each clock phase;
- the MSB-first assembly of bytes across an address that wraps from 0x..FF;
- the total edge and byte counts.

The bench's flash model and scoreboard cover these, both under random backpressure and with the consumer always ready.

// File: rtl/fbr_pkg.sv
// Package: shared constants and state type for the serial flash boot reader.
// Assumes a single read transaction per reset with 24-bit addressing.
package fbr_pkg;

    localparam logic [7:0] FBR_CMD_FAST_READ = 8'h0B;
    localparam int         FBR_ADDR_BITS     = 24;
    localparam int         FBR_DUMMY_BITS    = 8;
    localparam int         FBR_HDR_BITS      = 8 + FBR_ADDR_BITS + FBR_DUMMY_BITS;
    localparam int         FBR_BYTE_BITS     = 8;

    typedef enum logic [2:0] {
        FBR_IDLE    = 3'd0,
        FBR_HEADER  = 3'd1,
        FBR_DATA    = 3'd2,
        FBR_PRESENT = 3'd3,
        FBR_END     = 3'd4
    } fbr_state_t;

endpackage

// File: rtl/fbr_clkgen.sv
// Module: serial clock phase timer.
// Emits a one-cycle tick after every DIV cycles while run is high. The
// count restarts from zero whenever run is low, so each clock phase after
// a stall again lasts a full DIV cycles. Assumes DIV >= 1.
module fbr_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Phase counter: counts while running, clears when stopped or on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(DIV - 1));

endmodule

// File: rtl/fbr_tx_shifter.sv
// Module: parallel-load, MSB-first output shift register.
// load takes priority over shift; zeros fill in from the bottom.
module fbr_tx_shifter #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    output logic         bit_out
);
    logic [W-1:0] sr;

    // Shift register: load the header word or move it one bit toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign bit_out = sr[W-1];

endmodule

// File: rtl/fbr_rx_shifter.sv
// Module: MSB-first input shift register that assembles received bits.
// After W samples, the first sampled bit sits in the top position.
module fbr_rx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    // Assembly register: take one new bit in at the bottom on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (sample) begin
            word <= {word[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/fbr_seq.sv
// Module: transaction sequencer for the boot reader.
// Owns chip select, the serial clock level, bit and byte counters and the
// completion flags. A rising clock tick samples input data. A falling tick
// moves the outgoing header along. Assumes BYTE_COUNT >= 1.
module fbr_seq
    import fbr_pkg::*;
#(
    parameter int BYTE_COUNT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic out_ready,
    output logic run,
    output logic tx_load,
    output logic tx_shift,
    output logic rx_sample,
    output logic cs_n,
    output logic sck,
    output logic out_valid,
    output logic done,
    output logic released
);
    localparam int BIT_W = $clog2(FBR_HDR_BITS + 1);
    localparam int CNT_W = (BYTE_COUNT > 1) ? $clog2(BYTE_COUNT) : 1;

    fbr_state_t       state;
    logic [BIT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] byte_cnt;
    logic             rise_tick;
    logic             fall_tick;
    logic             last_byte;

    assign rise_tick = tick && !sck;
    assign fall_tick = tick &&  sck;
    assign last_byte = (byte_cnt == CNT_W'(BYTE_COUNT - 1));

    // Strobes for the clock timer and the shift registers.
    always_comb begin
        run       = (state == FBR_HEADER) || (state == FBR_DATA);
        tx_load   = (state == FBR_IDLE);
        tx_shift  = (state == FBR_HEADER) && fall_tick;
        rx_sample = (state == FBR_DATA) && rise_tick;
        out_valid = (state == FBR_PRESENT);
    end

    // Main state machine, pin levels and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FBR_IDLE;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            cs_n     <= 1'b1;
            sck      <= 1'b0;
            done     <= 1'b0;
            released <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                FBR_IDLE: begin
                    cs_n  <= 1'b0;
                    state <= FBR_HEADER;
                end
                FBR_HEADER: begin
                    if (rise_tick) begin
                        sck     <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (fall_tick) begin
                        sck <= 1'b0;
                        if (bit_cnt == BIT_W'(FBR_HDR_BITS)) begin
                            bit_cnt <= '0;
                            state   <= FBR_DATA;
                        end
                    end
                end
                FBR_DATA: begin
                    if (rise_tick) begin
                        sck     <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (fall_tick) begin
                        sck <= 1'b0;
                        if (bit_cnt == BIT_W'(FBR_BYTE_BITS)) begin
                            bit_cnt <= '0;
                            state   <= FBR_PRESENT;
                        end
                    end
                end
                FBR_PRESENT: begin
                    if (out_ready) begin
                        if (last_byte) begin
                            cs_n     <= 1'b1;
                            done     <= 1'b1;
                            released <= 1'b1;
                            state    <= FBR_END;
                        end else begin
                            byte_cnt <= byte_cnt + 1'b1;
                            state    <= FBR_DATA;
                        end
                    end
                end
                default: begin
                    cs_n <= 1'b1;
                    sck  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_boot_reader.sv
// Module: serial flash boot image reader (top).
// After reset it issues one Fast Read at START_ADDR in SPI mode 0 and
// streams BYTE_COUNT bytes out on a valid/ready interface. It then parks
// the pins and flags them as released. The serial clock half-period is
// CLK_DIV system clocks.
module flash_boot_reader
    import fbr_pkg::*;
#(
    parameter int          CLK_DIV    = 4,
    parameter logic [23:0] START_ADDR = 24'h000000,
    parameter int          BYTE_COUNT = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       done,
    output logic       pins_released
);
    localparam logic [FBR_HDR_BITS-1:0] HDR_WORD =
        {FBR_CMD_FAST_READ, START_ADDR, {FBR_DUMMY_BITS{1'b0}}};

    logic run;
    logic tick;
    logic tx_load;
    logic tx_shift;
    logic rx_sample;

    fbr_clkgen #(.DIV(CLK_DIV)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    fbr_tx_shifter #(.W(FBR_HDR_BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .shift    (tx_shift),
        .load_val (HDR_WORD),
        .bit_out  (spi_mosi)
    );

    fbr_rx_shifter #(.W(FBR_BYTE_BITS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (rx_sample),
        .bit_in (spi_miso),
        .word   (out_data)
    );

    fbr_seq #(.BYTE_COUNT(BYTE_COUNT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .out_ready (out_ready),
        .run       (run),
        .tx_load   (tx_load),
        .tx_shift  (tx_shift),
        .rx_sample (rx_sample),
        .cs_n      (spi_cs_n),
        .sck       (spi_sck),
        .out_valid (out_valid),
        .done      (done),
        .released  (pins_released)
    );

endmodule

// File: rtl/fbr_checker.sv
// Module: protocol checker for flash_boot_reader, bound to every instance.
// Checks pin relationships that must hold on every cycle after reset.
module fbr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       done,
    input logic       pins_released
);
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_mosi_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_stall_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !spi_sck);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_release_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pins_released |=> pins_released);

    p_release_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pins_released |-> (spi_cs_n && !spi_sck && !out_valid));

    p_release_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins_released) |-> done);

endmodule

bind flash_boot_reader fbr_checker u_fbr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .spi_cs_n      (spi_cs_n),
    .spi_sck       (spi_sck),
    .spi_mosi      (spi_mosi),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .done          (done),
    .pins_released (pins_released)
);

// File: tb/tb_flash_boot_reader.sv
module tb_flash_boot_reader;
    localparam int          CLK_PERIOD = 10;
    localparam int          DIV        = 2;
    localparam logic [23:0] ADDR       = 24'h0123F8;
    localparam int          NBYTES     = 20;
    localparam int          HDR        = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n, spi_sck, spi_mosi;
    logic       spi_miso = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       done, pins_released;

    int vectors = 0;
    int errors  = 0;

    flash_boot_reader #(
        .CLK_DIV    (DIV),
        .START_ADDR (ADDR),
        .BYTE_COUNT (NBYTES)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_cs_n      (spi_cs_n),
        .spi_sck       (spi_sck),
        .spi_mosi      (spi_mosi),
        .spi_miso      (spi_miso),
        .out_data      (out_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .done          (done),
        .pins_released (pins_released)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Image content of the modelled flash at a given address.
    function automatic logic [7:0] flash_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash model: counts rising edges, captures header bits, serves data.
    int          nrise = 0;
    logic [39:0] hdr   = '0;
    logic [23:0] rd_addr;
    always @(negedge spi_cs_n or posedge spi_sck) begin
        if (spi_sck) begin
            if (nrise < HDR) hdr = {hdr[38:0], spi_mosi};
            nrise = nrise + 1;
            if (nrise == 32) rd_addr = hdr[23:0];
        end else begin
            nrise = 0;
            hdr   = '0;
        end
    end
    always @(negedge spi_sck) begin
        if (nrise >= HDR) begin
            automatic int d = nrise - HDR;
            automatic logic [7:0] b = flash_byte(rd_addr + 24'(d / 8));
            spi_miso = b[7 - (d % 8)];
        end
    end

    // Scoreboard driver: expected image bytes, computed from the requirements.
    logic [7:0] exp_q[$];
    task automatic push_image();
        exp_q.delete();
        for (int k = 0; k < NBYTES; k++) exp_q.push_back(flash_byte(ADDR + 24'(k)));
    endtask

    // Consumer: random backpressure, or always ready.
    bit         rdy_always = 1'b0;
    logic [7:0] lfsr = 8'hB7;
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = rdy_always ? 1'b1 : (lfsr[0] & lfsr[2]);
        end
    end

    // Monitor: scoreboard pops, clock phase length, stall and done checks.
    int  got = 0;
    int  done_cnt = 0;
    int  hi_len = 0;
    int  nrise_at_valid = 0;
    bit  prev_valid = 1'b0;
    bit  mon_en = 1'b0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (spi_sck) hi_len++;
            else if (hi_len > 0) begin
                check(hi_len == DIV, "R6", "sck high phase length", 64'(hi_len), 64'(DIV));
                hi_len = 0;
            end
            if (out_valid && !prev_valid) nrise_at_valid = nrise;
            if (out_valid && out_ready) begin
                check(exp_q.size() > 0, "R9", "byte beyond image", 64'(got), 64'(NBYTES));
                if (exp_q.size() > 0) begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    check(out_data == e, "R7", "image byte", 64'(out_data), 64'(e));
                end
                check(nrise == nrise_at_valid && !spi_sck, "R8", "clock moved while byte pending",
                      64'(nrise), 64'(nrise_at_valid));
                check(!spi_cs_n, "R2", "cs_n low during transfer", 64'(spi_cs_n), 64'd0);
                got++;
            end
            if (done) begin
                done_cnt++;
                check(spi_cs_n && pins_released, "R9", "cs_n and release rise with done",
                      64'({spi_cs_n, pins_released}), 64'h3);
            end
            prev_valid = out_valid;
        end
    end

    initial begin
        for (int run = 0; run < 2; run++) begin
            rdy_always = (run == 1);
            mon_en = 1'b0;
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            // R1: reset state
            check(spi_cs_n && !spi_sck && !out_valid && !done && !pins_released, "R1",
                  "reset state", 64'({spi_cs_n, spi_sck, out_valid, done, pins_released}),
                  64'b10000);
            push_image();
            got = 0; done_cnt = 0; hi_len = 0; prev_valid = 1'b0;
            mon_en = 1'b1;
            rst_n = 1'b1;
            begin
                automatic int wd = 0;
                while (!pins_released && wd < 50000) begin
                    @(negedge clk);
                    wd++;
                end
                check(wd < 50000, "R9", "watchdog before done", 64'(wd), 64'd50000);
            end
            repeat (20) @(negedge clk);
            check(hdr[39:32] == 8'h0B, "R3", "command byte", 64'(hdr[39:32]), 64'h0B);
            check(hdr[31:8] == ADDR, "R4", "start address", 64'(hdr[31:8]), 64'(ADDR));
            check(hdr[7:0] == 8'h00, "R5", "dummy bits low", 64'(hdr[7:0]), 64'h0);
            check(nrise == HDR + 8*NBYTES, "R9", "total rising edges", 64'(nrise),
                  64'(HDR + 8*NBYTES));
            check(got == NBYTES && exp_q.size() == 0, "R9", "bytes delivered", 64'(got),
                  64'(NBYTES));
            check(done_cnt == 1, "R10", "done pulses", 64'(done_cnt), 64'd1);
            check(pins_released && spi_cs_n && !spi_sck && !out_valid, "R10",
                  "pins parked and released", 64'({pins_released, spi_cs_n, spi_sck, out_valid}),
                  64'b1100);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule